// File: doc/BRIEF.md
# Repeater Expansion Bus Interface

This block joins one multiport repeater to a shared expansion bus, so that several repeater devices cooperate as a single logical repeater. Whenever the local repeater has traffic (a port receiving, one or more ports colliding, or its elastic buffer still emptying onto the network), the block pulls its active-low request line. An external arbiter answers with an active-low acknowledge and an active-low collision line. The request/acknowledge pair decides the direction of the shared data and jam lines: the granted device drives them, while every other device listens to them while the bus is acknowledged, and all devices release them when no acknowledge is present.

While driving without a collision, the block places NRZ transmit data, preamble included, on the data line and holds jam low. On a local collision it raises jam and reuses the data line as a flag: 1 when exactly one local port collides, 0 when two or more do. On the receive side it passes the bus data and jam values through and decodes the multiport flag. It also issues a jam-generate command to the repeater core whenever the arbiter signals that several devices are active, a local collision is in progress, or a remote device is broadcasting jam.

The tri-state pins are not modelled as an inout; each shared line is split into an output-enable and an output-value, and the pad ring combines them.

Top module: `rep_xbus_if`

## Requirements
- R1: `req_n` is low in the cycle after an edge at which `rx_act`, `fifo_busy` or a nonzero `coll_cnt` is present, and high in the cycle after an edge at which none is present; after reset it is high.
- R2: When `ack_n` is 0 and `req_n` is 0, `dat_oe` and `jam_oe` are both 1 and `bus_valid` is 0.
- R3: When `ack_n` is 1, `dat_oe`, `jam_oe`, `bus_valid`, `bus_dat`, `bus_jam` and `rx_multi` are all 0.
- R4: When `ack_n` is 0 and `req_n` is 1, `dat_oe` and `jam_oe` are 0, `bus_valid` is 1, `bus_dat` equals `dat_in` and `bus_jam` equals `jam_in`.
- R5: While driving with `coll_cnt` equal to 0, `jam_out` is 0 and `dat_out` equals `tx_nrz`.
- R6: While driving with `coll_cnt` nonzero, `jam_out` is 1 and `dat_out` is 1 when `coll_cnt` equals 1 (single port) and 0 when it is 2 or more (multiport); `tx_nrz` has no effect on `dat_out`.
- R7: When not driving, `dat_out` and `jam_out` are 0.
- R8: `rx_multi` is 1 exactly when `bus_valid` is 1, `jam_in` is 1 and `dat_in` is 0.
- R9: `jam_gen` is 1 in the cycle after an edge at which `col_n` is 0.
- R10: `jam_gen` is 1 in the cycle after an edge at which `coll_cnt` is nonzero.
- R11: `jam_gen` is 1 in the cycle after an edge at which `bus_jam` is 1, and 0 after an edge at which none of the conditions of R9, R10 or this one hold; after reset it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_act | input | 1 | A local port is receiving |
| fifo_busy | input | 1 | Local buffer still transmitting |
| coll_cnt | input | CNT_W | Number of local ports in collision |
| tx_nrz | input | 1 | NRZ data to place on the bus |
| ack_n | input | 1 | Arbiter acknowledge, active low |
| col_n | input | 1 | Arbiter collision, active low |
| dat_in | input | 1 | Data line value seen at the pad |
| jam_in | input | 1 | Jam line value seen at the pad |
| req_n | output | 1 | Bus request, active low |
| dat_oe | output | 1 | Data line output enable |
| dat_out | output | 1 | Data line output value |
| jam_oe | output | 1 | Jam line output enable |
| jam_out | output | 1 | Jam line output value |
| bus_valid | output | 1 | Another device owns the bus; received values valid |
| bus_dat | output | 1 | Received data line value |
| bus_jam | output | 1 | Received jam line value |
| rx_multi | output | 1 | Received multiport collision flag |
| jam_gen | output | 1 | Command to generate the jam sequence |

## Verification
The bench sweeps every combination of receive flag, buffer flag, collision count from zero to the full port count, transmit bit, acknowledge, arbiter collision and both received line values. The idle rows against the active rows separate request generation from the acknowledge decoding; collision counts of 0, 1 and above 1 separate plain data forwarding from the single-port and multiport flags; and toggling `col_n`, `jam_in` and `dat_in` while listening tells the three sources of the jam command apart and shows that received values never leak out while the block is driving or released.

// File: rtl/rep_xbus_pkg.sv
package rep_xbus_pkg;

    typedef struct packed {
        logic rx;
        logic fifo;
        logic coll;
    } xbus_act_t;

    typedef struct packed {
        logic oe;
        logic dat;
        logic jam;
    } xbus_drv_t;

    typedef struct packed {
        logic valid;
        logic dat;
        logic jam;
        logic multi;
    } xbus_rcv_t;

    function automatic logic any_active(input xbus_act_t a);
        return a.rx | a.fifo | a.coll;
    endfunction

    function automatic xbus_drv_t drive_value(input logic grant, input logic coll,
                                              input logic single, input logic tx);
        xbus_drv_t d;
        d.oe  = grant;
        d.jam = grant & coll;
        d.dat = grant & (coll ? single : tx);
        return d;
    endfunction

endpackage

// File: rtl/rep_xbus_req.sv
module rep_xbus_req
    import rep_xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xbus_act_t act,
    output logic      req_n
);
    always_ff @(posedge clk) begin
        if (rst) req_n <= 1'b1;
        else     req_n <= ~any_active(act);
    end

    assert_req_on_R1: assert property (@(posedge clk) disable iff (rst)
        (act.rx || act.fifo || act.coll) |=> !req_n);
    assert_req_off_R1: assert property (@(posedge clk) disable iff (rst)
        !(act.rx || act.fifo || act.coll) |=> req_n);
endmodule

// File: rtl/rep_xbus_drv.sv
module rep_xbus_drv
    import rep_xbus_pkg::*;
(
    input  logic      req_n,
    input  logic      ack_n,
    input  logic      coll,
    input  logic      single,
    input  logic      tx_nrz,
    output xbus_drv_t drv
);
    logic grant;
    assign grant = ~req_n & ~ack_n;
    assign drv   = drive_value(grant, coll, single, tx_nrz);
endmodule

// File: rtl/rep_xbus_rcv.sv
module rep_xbus_rcv
    import rep_xbus_pkg::*;
(
    input  logic      req_n,
    input  logic      ack_n,
    input  logic      dat_in,
    input  logic      jam_in,
    output xbus_rcv_t rcv
);
    logic listen;
    assign listen    = req_n & ~ack_n;
    assign rcv.valid = listen;
    assign rcv.dat   = listen & dat_in;
    assign rcv.jam   = listen & jam_in;
    assign rcv.multi = listen & jam_in & ~dat_in;
endmodule

// File: rtl/rep_xbus_jam.sv
module rep_xbus_jam (
    input  logic clk,
    input  logic rst,
    input  logic col_n,
    input  logic coll,
    input  logic bus_jam,
    output logic jam_gen
);
    always_ff @(posedge clk) begin
        if (rst) jam_gen <= 1'b0;
        else     jam_gen <= ~col_n | coll | bus_jam;
    end

    assert_arb_col_R9: assert property (@(posedge clk) disable iff (rst)
        !col_n |=> jam_gen);
    assert_remote_jam_R11: assert property (@(posedge clk) disable iff (rst)
        bus_jam |=> jam_gen);
    assert_jam_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (col_n && !coll && !bus_jam) |=> !jam_gen);
endmodule

// File: rtl/rep_xbus_if.sv
module rep_xbus_if
    import rep_xbus_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    localparam int CNT_W    = $clog2(NUM_PORTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_act,
    input  logic             fifo_busy,
    input  logic [CNT_W-1:0] coll_cnt,
    input  logic             tx_nrz,
    input  logic             ack_n,
    input  logic             col_n,
    input  logic             dat_in,
    input  logic             jam_in,
    output logic             req_n,
    output logic             dat_oe,
    output logic             dat_out,
    output logic             jam_oe,
    output logic             jam_out,
    output logic             bus_valid,
    output logic             bus_dat,
    output logic             bus_jam,
    output logic             rx_multi,
    output logic             jam_gen
);
    xbus_act_t act;
    xbus_drv_t drv;
    xbus_rcv_t rcv;
    logic      coll_any;
    logic      coll_single;

    assign coll_any    = (coll_cnt != '0);
    assign coll_single = (coll_cnt == CNT_W'(1));
    assign act         = '{rx: rx_act, fifo: fifo_busy, coll: coll_any};

    rep_xbus_req u_req (.clk(clk), .rst(rst), .act(act), .req_n(req_n));

    rep_xbus_drv u_drv (
        .req_n(req_n), .ack_n(ack_n), .coll(coll_any),
        .single(coll_single), .tx_nrz(tx_nrz), .drv(drv)
    );

    rep_xbus_rcv u_rcv (
        .req_n(req_n), .ack_n(ack_n), .dat_in(dat_in), .jam_in(jam_in), .rcv(rcv)
    );

    rep_xbus_jam u_jam (
        .clk(clk), .rst(rst), .col_n(col_n), .coll(coll_any),
        .bus_jam(rcv.jam), .jam_gen(jam_gen)
    );

    assign dat_oe    = drv.oe;
    assign jam_oe    = drv.oe;
    assign dat_out   = drv.dat;
    assign jam_out   = drv.jam;
    assign bus_valid = rcv.valid;
    assign bus_dat   = rcv.dat;
    assign bus_jam   = rcv.jam;
    assign rx_multi  = rcv.multi;

    assert_no_contention_R2: assert property (@(posedge clk) disable iff (rst)
        !(dat_oe && bus_valid));
    assert_released_R3: assert property (@(posedge clk) disable iff (rst)
        ack_n |-> (!dat_oe && !jam_oe && !bus_valid));
    assert_single_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (jam_oe && coll_cnt == CNT_W'(1)) |-> (dat_out && jam_out));
    assert_multi_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (jam_oe && coll_cnt > CNT_W'(1)) |-> (!dat_out && jam_out));
    assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        !dat_oe |-> (!dat_out && !jam_out));
    assert_local_coll_R10: assert property (@(posedge clk) disable iff (rst)
        coll_any |=> jam_gen);
endmodule

// File: tb/rep_xbus_if_tb_top.sv
module rep_xbus_if_tb_top;
    localparam int NP = 8;
    localparam int CW = $clog2(NP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_act = 0, fifo_busy = 0, tx_nrz = 0, ack_n = 1, col_n = 1, dat_in = 0, jam_in = 0;
    logic [CW-1:0] coll_cnt = '0;
    logic req_n, dat_oe, dat_out, jam_oe, jam_out, bus_valid, bus_dat, bus_jam, rx_multi, jam_gen;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    rep_xbus_if #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst(rst), .rx_act(rx_act), .fifo_busy(fifo_busy), .coll_cnt(coll_cnt),
        .tx_nrz(tx_nrz), .ack_n(ack_n), .col_n(col_n), .dat_in(dat_in), .jam_in(jam_in),
        .req_n(req_n), .dat_oe(dat_oe), .dat_out(dat_out), .jam_oe(jam_oe), .jam_out(jam_out),
        .bus_valid(bus_valid), .bus_dat(bus_dat), .bus_jam(bus_jam), .rx_multi(rx_multi),
        .jam_gen(jam_gen)
    );

    task automatic chk(input string req, input string what, input logic act_v, input logic exp_v);
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act_v, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "req_n in reset", req_n, 1'b1);
        chk("R11", "jam_gen in reset", jam_gen, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "req_n after reset idle", req_n, 1'b1);
        chk("R11", "jam_gen after reset idle", jam_gen, 1'b0);
        chk("R3", "dat_oe released", dat_oe, 1'b0);

        for (int v = 0; v < 2 * 2 * (NP + 1) * 32; v++) begin
            int  c;
            logic a, e_req_n, e_drv, e_listen, coll, e_dat, e_jg;
            rx_act    = v[0];
            fifo_busy = v[1];
            tx_nrz    = v[2];
            ack_n     = v[3];
            col_n     = v[4];
            dat_in    = v[5];
            jam_in    = v[6];
            c         = v / 128;
            coll_cnt  = CW'(c);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            coll     = (c != 0);
            a        = rx_act | fifo_busy | coll;
            e_req_n  = ~a;
            e_drv    = ~ack_n & a;
            e_listen = ~ack_n & ~a;
            e_dat    = e_drv & (coll ? (c == 1) : tx_nrz);
            e_jg     = ~col_n | coll | (e_listen & jam_in);
            chk("R1", "req_n", req_n, e_req_n);
            chk(e_drv ? "R2" : (ack_n ? "R3" : "R4"), "dat_oe", dat_oe, e_drv);
            chk(e_drv ? "R2" : (ack_n ? "R3" : "R4"), "jam_oe", jam_oe, e_drv);
            chk(ack_n ? "R3" : "R4", "bus_valid", bus_valid, e_listen);
            chk(ack_n ? "R3" : "R4", "bus_dat", bus_dat, e_listen & dat_in);
            chk(ack_n ? "R3" : "R4", "bus_jam", bus_jam, e_listen & jam_in);
            chk(!e_drv ? "R7" : (coll ? "R6" : "R5"), "dat_out", dat_out, e_dat);
            chk(!e_drv ? "R7" : (coll ? "R6" : "R5"), "jam_out", jam_out, e_drv & coll);
            chk("R8", "rx_multi", rx_multi, e_listen & jam_in & ~dat_in);
            chk(!col_n ? "R9" : (coll ? "R10" : "R11"), "jam_gen", jam_gen, e_jg);
        end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule